// File: doc/BRIEF.md
# Tri-State Phase/Frequency Comparator with Lock Detector

This block closes the digital half of a synthesizer loop. It divides a reference tick stream by 512 or 1024 to make a reference strobe. It compares that strobe against a divided-feedback strobe and drives two charge-pump enables: raise (upper source) and lower (lower source). Both a phase error and a frequency error send the loop the right way. A feedback edge that comes first raises the upper source. A reference edge that comes first raises the lower source.

Each time a comparison completes, a short raise pulse of fixed width is appended. This keeps the pump working in its linear range. A two-bit mode input can override the outputs for testing: float them, force raise, or force lower. A level output passes the pump-current choice on to the analog pump. The lock flag is high while out of lock. It goes high on the clock after any one-sided pump pulse grows wider than a set window. It goes low again only at a reference strobe that closes one full reference period in which no such pulse occurred.

Top module: `phase_cmp_lock`

## Requirements
- R1: The reference strobe `ref_pulse` is high for one clock once every N accepted `ref_tick` cycles. N is 1024 when `ref_ratio_hi` is 1 and 512 when it is 0. `ref_ratio_hi` is sampled only at each strobe, where it sets the length of the following period. The first period after reset is always 512.
- R2: `mode_sel` selects the output function. 2'b00 is normal tracking. 2'b01 floats the pump: `pump_up`=0, `pump_dn`=0, `pump_hiz`=1. 2'b10 forces `pump_up`=1 and `pump_dn`=0. 2'b11 forces `pump_dn`=1 and `pump_up`=0. `pump_hiz` is 0 in every mode other than 2'b01.
- R3: In tracking mode, a `fb_pulse` latches the raise state and a reference strobe latches the lower state. A feedback edge ahead of the reference holds `pump_up`=1 with `pump_dn`=0, and a late feedback edge holds `pump_dn`=1 with `pump_up`=0.
- R4: When both states are latched, both clear at the next clock. Two coincident edges therefore give exactly one clock with both enables high.
- R5: Each clear starts an offset window that holds `pump_up` high for exactly OFFSET_CYC more clocks (default 2).
- R6: `pump_low_i` follows `low_current_sel` in every mode. A value of 1 requests the low pump current and 0 the high current.
- R7: A one-sided pump state lasting up to LOCK_WIN clocks (default 4) leaves the lock flag unchanged. If it lasts LOCK_WIN+1 clocks, `out_of_lock` goes to 1 on the following clock.
- R8: `out_of_lock` falls to 0 only on the clock after a reference strobe. This happens only when the whole previous reference period, strobe to strobe, held no unlock condition.
- R9: Reset state: `pump_up`=0, `pump_dn`=0, `pump_hiz`=0 in tracking mode, `ref_pulse`=0, `out_of_lock`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference oscillator tick (clock enable for the divider) |
| fb_pulse | input | 1 | One-clock strobe from the feedback divider |
| ref_ratio_hi | input | 1 | Reference ratio select: 1 gives 1024, 0 gives 512 |
| mode_sel | input | 2 | Output function select (see R2) |
| low_current_sel | input | 1 | Pump current choice, 1 = low |
| ref_pulse | output | 1 | Divided reference strobe |
| pump_up | output | 1 | Upper-source enable |
| pump_dn | output | 1 | Lower-source enable |
| pump_hiz | output | 1 | Pump floated flag |
| pump_low_i | output | 1 | Pump current level to the analog pump |
| out_of_lock | output | 1 | High while the loop is out of lock |

## Verification
The hardest conditions to reach from the ports are the two edges of the lock window: a late feedback edge exactly LOCK_WIN clocks behind the reference strobe, and one exactly one clock later. Relock then needs one more full clean period. The stimulus reaches these by watching `ref_pulse` and placing `fb_pulse` a counted number of clocks after it. Runs of aligned comparisons then check that relock waits a whole period. Random mode and current-select values are applied in idle stretches between comparisons.

// File: rtl/phc_pkg.sv
package phc_pkg;

    typedef enum logic [1:0] {
        MODE_TRACK = 2'b00,
        MODE_FLOAT = 2'b01,
        MODE_PUSH  = 2'b10,
        MODE_PULL  = 2'b11
    } pump_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic hiz;
    } pump_t;

    // Maps the tracking enables through the selected output function.
    function automatic pump_t drive_pump(pump_mode_e m, logic up, logic dn);
        pump_t p;
        unique case (m)
            MODE_TRACK: p = '{up: up,   dn: dn,   hiz: 1'b0};
            MODE_FLOAT: p = '{up: 1'b0, dn: 1'b0, hiz: 1'b1};
            MODE_PUSH:  p = '{up: 1'b1, dn: 1'b0, hiz: 1'b0};
            default:    p = '{up: 1'b0, dn: 1'b1, hiz: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/phc_refdiv.sv
module phc_refdiv #(
    parameter int DIV_LO = 512,
    parameter int DIV_HI = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ratio_hi,
    output logic ref_evt
);
    localparam int CNT_W = $clog2(DIV_HI);
    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             hi_q;
    logic [CNT_W-1:0] last;

    assign last = hi_q ? LAST_HI : LAST_LO;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            hi_q    <= 1'b0;
            ref_evt <= 1'b0;
        end else begin
            ref_evt <= 1'b0;
            if (tick) begin
                if (cnt_q == last) begin
                    cnt_q   <= '0;
                    ref_evt <= 1'b1;
                    hi_q    <= ratio_hi;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R1: strobe lasts one clock
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
        ref_evt |=> !ref_evt);
    // R1: count never passes the active ratio
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);

endmodule

// File: rtl/phc_pfd_core.sv
module phc_pfd_core #(
    parameter int OFFSET_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_evt,
    input  logic fb_evt,
    output logic up_q,
    output logic dn_q,
    output logic ofs_on
);
    localparam int OFS_W = $clog2(OFFSET_CYC + 1);
    localparam logic [OFS_W-1:0] OFS_LOAD = OFS_W'(OFFSET_CYC);

    logic [OFS_W-1:0] ofs_q;
    logic             both;

    assign both   = up_q & dn_q;
    assign ofs_on = (ofs_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q  <= 1'b0;
            dn_q  <= 1'b0;
            ofs_q <= '0;
        end else if (both) begin
            up_q  <= 1'b0;
            dn_q  <= 1'b0;
            ofs_q <= OFS_LOAD;
        end else begin
            up_q <= up_q | fb_evt;
            dn_q <= dn_q | ref_evt;
            if (ofs_on) ofs_q <= ofs_q - 1'b1;
        end
    end

    // R4: coincident state clears after one clock of overlap
    p_overlap_one_r4: assert property (@(posedge clk) disable iff (rst)
        (up_q && dn_q) |=> (!up_q && !dn_q));
    // R5: a completed comparison opens the offset window
    p_offset_start_r5: assert property (@(posedge clk) disable iff (rst)
        (up_q && dn_q) |=> ofs_on);

endmodule

// File: rtl/phc_lock_det.sv
module phc_lock_det #(
    parameter int LOCK_WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic up_q,
    input  logic dn_q,
    input  logic ref_evt,
    output logic out_of_lock
);
    localparam int W_W = $clog2(LOCK_WIN + 1);
    localparam logic [W_W-1:0] WIN = W_W'(LOCK_WIN);

    logic [W_W-1:0] wcnt_q;
    logic           one_sided;
    logic           viol;
    logic           clean_q;

    assign one_sided = up_q ^ dn_q;
    assign viol      = one_sided && (wcnt_q == WIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q      <= '0;
            clean_q     <= 1'b0;
            out_of_lock <= 1'b1;
        end else begin
            if (!one_sided)        wcnt_q <= '0;
            else if (wcnt_q != WIN) wcnt_q <= wcnt_q + 1'b1;

            if (viol) begin
                clean_q     <= 1'b0;
                out_of_lock <= 1'b1;
            end else if (ref_evt) begin
                clean_q <= 1'b1;
                if (clean_q) out_of_lock <= 1'b0;
            end
        end
    end

    // R7: an over-wide one-sided pulse flags unlock on the next clock
    p_unlock_next_r7: assert property (@(posedge clk) disable iff (rst)
        viol |=> out_of_lock);
    // R8: the flag clears only right after a reference strobe
    p_relock_ref_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(out_of_lock) |-> $past(ref_evt));

endmodule

// File: rtl/phase_cmp_lock.sv
module phase_cmp_lock #(
    parameter int DIV_LO     = 512,
    parameter int DIV_HI     = 1024,
    parameter int OFFSET_CYC = 2,
    parameter int LOCK_WIN   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick,
    input  logic       fb_pulse,
    input  logic       ref_ratio_hi,
    input  logic [1:0] mode_sel,
    input  logic       low_current_sel,
    output logic       ref_pulse,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_hiz,
    output logic       pump_low_i,
    output logic       out_of_lock
);
    import phc_pkg::*;

    logic  up_q, dn_q, ofs_on;
    pump_t pump;

    phc_refdiv #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_refdiv (
        .clk(clk), .rst(rst), .tick(ref_tick),
        .ratio_hi(ref_ratio_hi), .ref_evt(ref_pulse)
    );

    phc_pfd_core #(.OFFSET_CYC(OFFSET_CYC)) u_core (
        .clk(clk), .rst(rst), .ref_evt(ref_pulse), .fb_evt(fb_pulse),
        .up_q(up_q), .dn_q(dn_q), .ofs_on(ofs_on)
    );

    phc_lock_det #(.LOCK_WIN(LOCK_WIN)) u_lock (
        .clk(clk), .rst(rst), .up_q(up_q), .dn_q(dn_q),
        .ref_evt(ref_pulse), .out_of_lock(out_of_lock)
    );

    assign pump       = drive_pump(pump_mode_e'(mode_sel), up_q | ofs_on, dn_q);
    assign pump_up    = pump.up;
    assign pump_dn    = pump.dn;
    assign pump_hiz   = pump.hiz;
    assign pump_low_i = low_current_sel;

    // R2: floating mode silences both enables
    p_float_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01) |-> (pump_hiz && !pump_up && !pump_dn));
    // R2: forced modes never drive both sources
    p_force_excl_r2: assert property (@(posedge clk) disable iff (rst)
        mode_sel[1] |-> ($countones({pump_up, pump_dn}) == 1 && !pump_hiz));

endmodule

// File: tb/phase_cmp_lock_tb.sv
module phase_cmp_lock_tb;
    localparam int DLO = 512;
    localparam int DHI = 1024;
    localparam int OFS = 2;
    localparam int WIN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_tick = 1'b1;
    logic fb_pulse = 1'b0;
    logic ref_ratio_hi = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic low_current_sel = 1'b0;
    logic ref_pulse, pump_up, pump_dn, pump_hiz, pump_low_i, out_of_lock;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phase_cmp_lock #(.DIV_LO(DLO), .DIV_HI(DHI), .OFFSET_CYC(OFS), .LOCK_WIN(WIN)) u_dut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .fb_pulse(fb_pulse),
        .ref_ratio_hi(ref_ratio_hi), .mode_sel(mode_sel),
        .low_current_sel(low_current_sel), .ref_pulse(ref_pulse),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
        .pump_low_i(pump_low_i), .out_of_lock(out_of_lock)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected {up,dn,hiz} for a mode while the tracking state is idle.
    function automatic logic [2:0] exp_idle(input logic [1:0] m);
        case (m)
            2'b00:   return 3'b000;
            2'b01:   return 3'b001;
            2'b10:   return 3'b100;
            default: return 3'b010;
        endcase
    endfunction

    // Waits for the reference strobe; returns the cycle stamp.
    task automatic wait_ref(output int t);
        do @(negedge clk); while (!ref_pulse);
        t = cyc;
    endtask

    // Feedback strobe in the same clock the reference state latches.
    task automatic aligned_cmp(input bit chk_wave, output int t,
                               output logic lk_seen, output logic lk_after);
        wait_ref(t);
        lk_seen = out_of_lock;
        fb_pulse = 1'b1;
        @(negedge clk); fb_pulse = 1'b0;
        lk_after = out_of_lock;
        if (chk_wave) begin
            chk("R4", "overlap up", pump_up, 1);
            chk("R4", "overlap dn", pump_dn, 1);
        end
        for (int i = 1; i <= OFS + 1; i++) begin
            @(negedge clk);
            if (chk_wave) begin
                chk("R5", $sformatf("offset up at +%0d", i), pump_up, (i <= OFS) ? 1 : 0);
                chk("R4", $sformatf("dn cleared at +%0d", i), pump_dn, 0);
            end
        end
    endtask

    // Feedback strobe d clocks late relative to the aligned position.
    task automatic late_cmp(input int d);
        int t;
        wait_ref(t);
        for (int i = 1; i <= d; i++) @(negedge clk);
        chk("R3", "late fb: dn held", pump_dn, 1);
        chk("R3", "late fb: up idle", pump_up, 0);
        chk("R7", "lock before window end", out_of_lock, 0);
        fb_pulse = 1'b1;
        @(negedge clk); fb_pulse = 1'b0;
        chk("R7", $sformatf("lock after late by %0d", d), out_of_lock, (d > WIN) ? 1 : 0);
        repeat (OFS + 2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int t0, t1, seed;
        logic ls, la;
        seed = $urandom(32'h1c0ffee);

        repeat (3) @(negedge clk);
        chk("R9", "reset up", pump_up, 0);
        chk("R9", "reset dn", pump_dn, 0);
        chk("R9", "reset hiz", pump_hiz, 0);
        chk("R9", "reset strobe", ref_pulse, 0);
        chk("R9", "reset lock flag", out_of_lock, 1);

        // R1: high ratio requested from reset; first period still 512
        ref_ratio_hi = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk); t0 = cyc;
        aligned_cmp(1'b1, t1, ls, la);
        chk("R1", "first period after reset", t1 - t0, DLO);
        t0 = t1;
        aligned_cmp(1'b0, t1, ls, la);
        chk("R1", "period with ratio 1024", t1 - t0, DHI);
        chk("R8", "flag at second strobe", ls, 1);
        chk("R8", "flag clears after clean period", la, 0);
        repeat (100) @(negedge clk);
        ref_ratio_hi = 1'b0;
        t0 = t1;
        aligned_cmp(1'b0, t1, ls, la);
        chk("R1", "mid-period change ignored", t1 - t0, DHI);
        t0 = t1;
        aligned_cmp(1'b1, t1, ls, la);
        chk("R1", "new ratio 512 after strobe", t1 - t0, DLO);
        chk("R8", "lock held on aligned edges", la, 0);

        // R7: window edge, tolerated then exceeded
        late_cmp(WIN);
        late_cmp(WIN + 1);
        aligned_cmp(1'b0, t1, ls, la);
        chk("R8", "no relock in the tainted period", la, 1);
        aligned_cmp(1'b0, t1, ls, la);
        chk("R8", "relock after full clean period", la, 0);

        // R2 / R6: random output modes in an idle stretch
        for (int k = 0; k < 40; k++) begin
            logic [2:0] e;
            @(negedge clk);
            mode_sel = 2'($urandom_range(0, 3));
            low_current_sel = 1'($urandom_range(0, 1));
            if (k < 4) mode_sel = 2'(k);
            #1;
            e = exp_idle(mode_sel);
            chk("R2", $sformatf("mode %0d up", mode_sel), pump_up, e[2]);
            chk("R2", $sformatf("mode %0d dn", mode_sel), pump_dn, e[1]);
            chk("R2", $sformatf("mode %0d hiz", mode_sel), pump_hiz, e[0]);
            chk("R6", "current select level", pump_low_i, low_current_sel);
        end
        @(negedge clk);
        mode_sel = 2'b00;
        low_current_sel = 1'b0;

        // R3 / R7: feedback ahead of the reference
        repeat (20) @(negedge clk);
        fb_pulse = 1'b1;
        @(negedge clk); fb_pulse = 1'b0;
        chk("R3", "early fb: up held", pump_up, 1);
        chk("R3", "early fb: dn idle", pump_dn, 0);
        chk("R7", "lock before window end (early)", out_of_lock, 0);
        repeat (WIN + 2) @(negedge clk);
        chk("R7", "early fb unlocks", out_of_lock, 1);
        mode_sel = 2'b01;
        #1;
        chk("R2", "float masks held up state", pump_up, 0);
        @(negedge clk); mode_sel = 2'b00;
        #1;
        chk("R3", "up state kept through float", pump_up, 1);
        aligned_cmp(1'b1, t1, ls, la);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule